// File: doc/BRIEF.md
# Region protection and translation unit

This block translates and checks every memory access against a small table of eight fixed-size regions that together cover the 32-bit address space. The top three address bits pick a region. Each region holds a replacement for those top bits and a 4-bit attribute code. The physical address is the region's base bits placed above the untouched lower 29 address bits.

The attribute code is expanded into read, write and execute permissions and a cache policy. The access kind (read, write or instruction fetch) is then checked against those permissions. The answer is registered and comes out one cycle after the request, with a fault flag and a cause code. A single write port replaces the contents of one region.

An instruction-side copy and a data-side copy may be instantiated side by side. Each copy keeps its own table.

Top module: `region_xlate_unit`

## Requirements
- R1: After reset, region i maps to base i (identity) with attribute 2, so every region allows read, write and execute with policy bypass. rsp_valid is low while reset is held and in the first cycle after it.
- R2: The region index is req_addr[31:29]. rsp_paddr is the region's 3-bit base in bits [31:29], with req_addr[28:0] copied unchanged below it.
- R3: A request accepted with req_valid high produces rsp_valid high in the following cycle. A cycle with no request produces rsp_valid low in the following cycle.
- R4: Attribute decode, with rsp_cache coded as 0 bypass, 1 write-through, 2 write-back and 3 isolate:
  - code 0 gives read and write, policy 1.
  - code 1 gives read, write and execute, policy 1.
  - code 2 gives read, write and execute, policy 0.
  - code 3 gives execute only, policy 2.
- R5: Codes 4 and 5 give read, write and execute with policy 2. Code 14 gives read and write with policy 3. Every other code grants no permission and reports policy 0.
- R6: req_kind is coded 0 read, 1 write, 2 fetch. An access lacking the matching permission faults with rsp_cause 1 for a read, 2 for a write and 3 for a fetch. A granted access has rsp_cause 0. rsp_fault is high exactly when rsp_cause is nonzero.
- R7: req_kind 3 is always denied with rsp_cause 4, whatever the region's attribute.
- R8: With cfg_we high, region cfg_idx takes cfg_data[31:29] as its base and cfg_data[3:0] as its attribute. cfg_data[28:4] is ignored and the other regions are unchanged.
- R9: A request in the same cycle as a write to its region sees the region's old contents. A request in the next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Virtual address of the access |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 illegal |
| cfg_we | input | 1 | Region table write strobe |
| cfg_idx | input | 3 | Region to write |
| cfg_data | input | 32 | New base in [31:29], new attribute in [3:0] |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_read | output | 1 | Region allows reads |
| rsp_write | output | 1 | Region allows writes |
| rsp_exec | output | 1 | Region allows fetches |
| rsp_cache | output | 2 | Cache policy: 0 bypass, 1 write-through, 2 write-back, 3 isolate |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | 3 | 0 none, 1 load, 2 store, 3 fetch, 4 illegal kind |

## Verification
The hardest case to reach from the ports is a table write and a lookup that land on the same region in the same cycle. In that case the response must reflect the contents from before the write. The stimulus drives cfg_we and req_valid on one clock edge for the same index, with a new attribute that changes the permissions. It then repeats the lookup on the next edge, so that the old and new answers differ in both the fault and the policy fields. All sixteen attribute codes are also loaded into one region, with garbage in the ignored middle bits of the write data, and each code is probed with every access kind.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_LOAD  = 3'd1,
    CAUSE_STORE = 3'd2,
    CAUSE_FETCH = 3'd3,
    CAUSE_KIND  = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    POL_BYPASS = 2'd0,
    POL_WTHRU  = 2'd1,
    POL_WBACK  = 2'd2,
    POL_ISOL   = 2'd3
  } policy_e;

  typedef struct packed {
    logic    rd;
    logic    wr;
    logic    ex;
    policy_e pol;
  } perm_t;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;
endpackage

// File: rtl/rxu_region_table.sv
module rxu_region_table #(
  parameter int IDX_W  = 3,
  parameter int BASE_W = 3,
  parameter int ATTR_W = 4,
  parameter logic [ATTR_W-1:0] RST_ATTR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BASE_W-1:0] wbase,
  input  logic [ATTR_W-1:0] wattr,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BASE_W-1:0] rbase,
  output logic [ATTR_W-1:0] rattr
);
  localparam int NREG = 1 << IDX_W;

  logic [BASE_W-1:0] base_q [NREG];
  logic [ATTR_W-1:0] attr_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= BASE_W'(i);
        attr_q[i] <= RST_ATTR;
      end
    end else if (we) begin
      base_q[widx] <= wbase;
      attr_q[widx] <= wattr;
    end
  end

  // Read is asynchronous: a same-cycle write shows up only after the edge.
  assign rbase = base_q[ridx];
  assign rattr = attr_q[ridx];
endmodule

// File: rtl/rxu_attr_decode.sv
module rxu_attr_decode
  import rxu_pkg::*;
#(
  parameter int ATTR_W = 4
) (
  input  logic [ATTR_W-1:0] attr,
  output perm_t             perm
);
  always_comb begin
    perm = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, pol: POL_BYPASS};
    case (attr)
      ATTR_W'(0):  perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, pol: POL_WTHRU};
      ATTR_W'(1):  perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_WTHRU};
      ATTR_W'(2):  perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_BYPASS};
      ATTR_W'(3):  perm = '{rd: 1'b0, wr: 1'b0, ex: 1'b1, pol: POL_WBACK};
      ATTR_W'(4),
      ATTR_W'(5):  perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_WBACK};
      ATTR_W'(14): perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, pol: POL_ISOL};
      default:     perm = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, pol: POL_BYPASS};
    endcase
  end
endmodule

// File: rtl/rxu_access_check.sv
module rxu_access_check
  import rxu_pkg::*;
(
  input  logic [1:0] kind,
  input  perm_t      perm,
  output cause_e     cause
);
  always_comb begin
    case (kind)
      KIND_READ:  cause = perm.rd ? CAUSE_NONE : CAUSE_LOAD;
      KIND_WRITE: cause = perm.wr ? CAUSE_NONE : CAUSE_STORE;
      KIND_FETCH: cause = perm.ex ? CAUSE_NONE : CAUSE_FETCH;
      default:    cause = CAUSE_KIND;
    endcase
  end
endmodule

// File: rtl/region_xlate_unit.sv
module region_xlate_unit
  import rxu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_read,
  output logic              rsp_write,
  output logic              rsp_exec,
  output logic [1:0]        rsp_cache,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause
);
  localparam int OFF_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_base;
  logic [ATTR_W-1:0] lk_attr;
  perm_t             lk_perm;
  cause_e            lk_cause;

  rxu_region_table #(
    .IDX_W (IDX_W),
    .BASE_W(IDX_W),
    .ATTR_W(ATTR_W)
  ) u_table (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .widx (cfg_idx),
    .wbase(cfg_data[ADDR_W-1:OFF_W]),
    .wattr(cfg_data[ATTR_W-1:0]),
    .ridx (req_addr[ADDR_W-1:OFF_W]),
    .rbase(lk_base),
    .rattr(lk_attr)
  );

  rxu_attr_decode #(.ATTR_W(ATTR_W)) u_dec (
    .attr(lk_attr),
    .perm(lk_perm)
  );

  rxu_access_check u_chk_acc (
    .kind (req_kind),
    .perm (lk_perm),
    .cause(lk_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_read  <= 1'b0;
      rsp_write <= 1'b0;
      rsp_exec  <= 1'b0;
      rsp_cache <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= {lk_base, req_addr[OFF_W-1:0]};
        rsp_read  <= lk_perm.rd;
        rsp_write <= lk_perm.wr;
        rsp_exec  <= lk_perm.ex;
        rsp_cache <= lk_perm.pol;
        rsp_fault <= (lk_cause != CAUSE_NONE);
        rsp_cause <= lk_cause;
      end
    end
  end
endmodule

// File: rtl/rxu_checker.sv
module rxu_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_kind,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_read,
  input logic              rsp_write,
  input logic              rsp_exec,
  input logic              rsp_fault,
  input logic [2:0]        rsp_cause
);
  localparam int OFF_W = ADDR_W - IDX_W;

  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));

  assert_fault_cause_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

  assert_read_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd0) |=> (rsp_fault != rsp_read));

  assert_write_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd1) |=> (rsp_fault != rsp_write));

  assert_fetch_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd2) |=> (rsp_fault != rsp_exec));

  assert_bad_kind_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd3) |=> (rsp_fault && rsp_cause == 3'd4));
endmodule

bind region_xlate_unit rxu_checker #(
  .ADDR_W(ADDR_W),
  .IDX_W (IDX_W)
) u_rxu_checker (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_addr (req_addr),
  .req_kind (req_kind),
  .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr),
  .rsp_read (rsp_read),
  .rsp_write(rsp_write),
  .rsp_exec (rsp_exec),
  .rsp_fault(rsp_fault),
  .rsp_cause(rsp_cause)
);

// File: tb/sim_region_xlate_unit.sv
module sim_region_xlate_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_data;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_read, rsp_write, rsp_exec;
  logic [1:0]  rsp_cache;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;

  always #5 clk = ~clk;

  region_xlate_unit u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_read(rsp_read), .rsp_write(rsp_write), .rsp_exec(rsp_exec),
    .rsp_cache(rsp_cache), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  typedef struct {
    logic [31:0] pa;
    logic [2:0]  rwx;
    logic [1:0]  pol;
    logic        flt;
    logic [2:0]  cause;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  logic [2:0] m_base [8];
  logic [3:0] m_attr [8];

  // Reference decode, written from R4/R5: returns {r,w,x,policy}
  function automatic logic [4:0] ref_decode(logic [3:0] a);
    case (a)
      4'd0:        return {3'b110, 2'd1};
      4'd1:        return {3'b111, 2'd1};
      4'd2:        return {3'b111, 2'd0};
      4'd3:        return {3'b001, 2'd2};
      4'd4, 4'd5:  return {3'b111, 2'd2};
      4'd14:       return {3'b110, 2'd3};
      default:     return {3'b000, 2'd0};
    endcase
  endfunction

  task automatic fail_line(string tag, string what, int act, int expv);
    n_fail++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
  endtask

  // One cycle of stimulus; the expectation uses the table as it stands
  // before this cycle's write (R9).
  task automatic step(bit dreq, logic [31:0] a, logic [1:0] k,
                      bit dcfg, logic [2:0] ci, logic [31:0] cd, string tag);
    @(negedge clk);
    req_valid = dreq; req_addr = a; req_kind = k;
    cfg_we = dcfg; cfg_idx = ci; cfg_data = cd;
    if (dreq) begin
      exp_t e;
      logic [4:0] d;
      logic [2:0] ri;
      ri = a[31:29];
      d = ref_decode(m_attr[ri]);
      e.pa  = {m_base[ri], a[28:0]};
      e.rwx = d[4:2];
      e.pol = d[1:0];
      case (k)
        2'd0: e.cause = d[4] ? 3'd0 : 3'd1;
        2'd1: e.cause = d[3] ? 3'd0 : 3'd2;
        2'd2: e.cause = d[2] ? 3'd0 : 3'd3;
        default: e.cause = 3'd4;
      endcase
      e.flt = (e.cause != 3'd0);
      e.tag = tag;
      exp_q.push_back(e);
    end
    if (dcfg) begin
      m_base[ci] = cd[31:29];
      m_attr[ci] = cd[3:0];
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 32'h0, 2'd0, 0, 3'd0, 32'h0, "");
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          fail_line("R3", "unexpected rsp_valid", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (rsp_paddr !== e.pa) fail_line(e.tag, "paddr", rsp_paddr, e.pa);
          else if ({rsp_read, rsp_write, rsp_exec} !== e.rwx)
            fail_line(e.tag, "rwx", {rsp_read, rsp_write, rsp_exec}, e.rwx);
          else if (rsp_cache !== e.pol) fail_line(e.tag, "cache", rsp_cache, e.pol);
          else if (rsp_fault !== e.flt) fail_line(e.tag, "fault", rsp_fault, e.flt);
          else if (rsp_cause !== e.cause) fail_line(e.tag, "cause", rsp_cause, e.cause);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 0; req_addr = 0; req_kind = 0;
    cfg_we = 0; cfg_idx = 0; cfg_data = 0;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 3'(i);
      m_attr[i] = 4'd2;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) fail_line("R1", "rsp_valid after reset", rsp_valid, 0);

    // R1 / R2: identity map with attribute 2 in every region, all kinds
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 3; k++)
        step(1, {3'(r), 29'h0ABC_123 + 29'(r * 4099 + k)}, 2'(k), 0, 3'd0, 32'h0, "R1");

    // R8 / R2: relocate region 6 to base 1, garbage in the ignored bits
    step(0, 0, 0, 1, 3'd6, {3'd1, 25'h1FF_FFFF, 4'd4}, "R8");
    step(1, {3'd6, 29'h1234_5678}, 2'd1, 0, 3'd0, 32'h0, "R2");
    step(1, {3'd7, 29'h0000_0010}, 2'd0, 0, 3'd0, 32'h0, "R8");

    // R4 / R5 / R6: every attribute code against every kind in region 5
    for (int a = 0; a < 16; a++) begin
      step(0, 0, 0, 1, 3'd5, {3'd3, 25'h0AA_5555, 4'(a)}, "R8");
      for (int k = 0; k < 3; k++)
        step(1, {3'd5, 29'h0F0F_0F00 + 29'(a)}, 2'(k), 0, 3'd0, 32'h0,
             (a < 4) ? "R4" : "R5");
    end

    // R7: illegal kind on a fully permissive region and on a dead one
    step(1, {3'd0, 29'h0000_0044}, 2'd3, 0, 3'd0, 32'h0, "R7");
    step(1, {3'd5, 29'h0000_0044}, 2'd3, 0, 3'd0, 32'h0, "R7");

    // R6: back-to-back mixed kinds on an execute-only region
    step(0, 0, 0, 1, 3'd2, {3'd4, 25'h0, 4'd3}, "R8");
    step(1, {3'd2, 29'h0000_1000}, 2'd0, 0, 3'd0, 32'h0, "R6");
    step(1, {3'd2, 29'h0000_1004}, 2'd1, 0, 3'd0, 32'h0, "R6");
    step(1, {3'd2, 29'h0000_1008}, 2'd2, 0, 3'd0, 32'h0, "R6");

    // R9: same-cycle write and lookup on region 3, then the next cycle
    step(1, {3'd3, 29'h0000_0200}, 2'd1, 1, 3'd3, {3'd7, 25'h0, 4'd3}, "R9");
    step(1, {3'd3, 29'h0000_0200}, 2'd1, 0, 3'd0, 32'h0, "R9");
    step(1, {3'd3, 29'h0000_0204}, 2'd2, 0, 3'd0, 32'h0, "R9");

    // R3: an idle cycle gives no response
    idle(1);
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) fail_line("R3", "rsp_valid after idle", rsp_valid, 0);
    idle(2);
    n_chk++;
    if (exp_q.size() != 0) fail_line("R3", "missing responses", exp_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule